// File: doc/BRIEF.md
# Extended data pointer address former

This block builds the wide addresses used when a processor core reaches memory through its data pointers. There are two 16-bit data pointers, and each has its own 6-bit page register. An external-data transfer uses the selected pointer together with its page, which gives a 22-bit address. The table-read and indirect-jump forms work differently. They add the unsigned accumulator to the selected pointer, let the sum wrap inside 16 bits, and put the page of the currently executing instruction on top. The pointer's page register plays no part in those two forms.

The core feeds in the current pointer and page values, a pointer select bit, the accumulator, the current code page and one operation strobe per cycle. The block registers the formed address one clock after an address-forming strobe and holds it at all other times. The updated pointer and page values come out combinationally, ready for the core to write back. An increment or decrement changes only the low 16 bits of the selected pointer.

Top module: `ext_addr_former`

## Requirements
- R1: While `rst` is high at a clock edge, `addr_q` becomes 0 at that edge.
- R2: One clock after `op_xdata` is sampled high, `addr_q` equals {page, pointer} of the selected pair. Pair 0 is {`page0`, `ptr0`} when `ptr_sel`=0; pair 1 is {`page1`, `ptr1`} when `ptr_sel`=1.
- R3: While `op_inc` is high, the selected pointer output equals its input plus 1, modulo 2^16. So FFFFh becomes 0000h, and both page outputs equal their inputs.
- R4: While `op_dec` is high, the selected pointer output equals its input minus 1, modulo 2^16. So 0000h becomes FFFFh, and both page outputs equal their inputs.
- R5: One clock after `op_tblrd` or `op_ijmp` is sampled high, `addr_q[21:16]` equals `code_page` and `addr_q[15:0]` equals (selected pointer + `acc`) mod 2^16. `page0` and `page1` have no effect on the result.
- R6: The unselected pointer output always equals its input. Both page outputs always equal their inputs. With neither `op_inc` nor `op_dec` high, both pointer outputs equal their inputs.
- R7: A clock edge at which none of `op_xdata`, `op_tblrd` and `op_ijmp` is high leaves `addr_q` unchanged.
- R8: `acc` is an unsigned 8-bit value. Values 80h to FFh are added as 128 to 255 in the R5 sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptr_sel | input | 1 | Selects pointer pair 0 or 1 |
| ptr0 | input | 16 | Data pointer 0 |
| ptr1 | input | 16 | Data pointer 1 |
| page0 | input | 6 | Page register of pointer 0 |
| page1 | input | 6 | Page register of pointer 1 |
| acc | input | 8 | Accumulator, unsigned index |
| code_page | input | 6 | Page of the executing instruction |
| op_xdata | input | 1 | External-data transfer through the pointer |
| op_tblrd | input | 1 | Accumulator-indexed table read |
| op_ijmp | input | 1 | Accumulator-indexed jump |
| op_inc | input | 1 | Increment selected pointer |
| op_dec | input | 1 | Decrement selected pointer |
| addr_q | output | 22 | Registered formed address |
| ptr0_nx | output | 16 | Updated pointer 0 |
| ptr1_nx | output | 16 | Updated pointer 1 |
| page0_nx | output | 6 | Updated page 0 |
| page1_nx | output | 6 | Updated page 1 |

## Verification
The bench builds the block with the package defaults: 16-bit pointers, 6-bit pages and an 8-bit accumulator. At these widths the wrap points FFFFh and 0000h, and the top half of the accumulator range, can be driven directly. Directed cases set page registers that differ from the code page, so the page source of each form shows in the result. Random cases mix all strobes and both pointer selects. Idle cycles test that the address holds.

// File: rtl/xaddr_pkg.sv
package xaddr_pkg;
    localparam int PTR_W  = 16;
    localparam int PAGE_W = 6;
    localparam int ACC_W  = 8;
    localparam int ADDR_W = PAGE_W + PTR_W;
    localparam int NPTR   = 2;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_XDATA,
        OP_TBL,
        OP_JUMP,
        OP_INC,
        OP_DEC
    } op_e;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [PTR_W-1:0]  lo;
    } xptr_t;

    function automatic logic [PTR_W-1:0] index_add(
        input logic [PTR_W-1:0] base,
        input logic [ACC_W-1:0] idx
    );
        return base + {{(PTR_W-ACC_W){1'b0}}, idx};
    endfunction

    function automatic logic forms_addr(input op_e op);
        return (op == OP_XDATA) || (op == OP_TBL) || (op == OP_JUMP);
    endfunction
endpackage

// File: rtl/xaddr_op_decode.sv
module xaddr_op_decode
    import xaddr_pkg::*;
(
    input  logic op_xdata,
    input  logic op_tblrd,
    input  logic op_ijmp,
    input  logic op_inc,
    input  logic op_dec,
    output op_e  op
);
    always_comb begin
        if (op_xdata)      op = OP_XDATA;
        else if (op_tblrd) op = OP_TBL;
        else if (op_ijmp)  op = OP_JUMP;
        else if (op_inc)   op = OP_INC;
        else if (op_dec)   op = OP_DEC;
        else               op = OP_NONE;
    end
endmodule

// File: rtl/xaddr_ptr_step.sv
module xaddr_ptr_step
    import xaddr_pkg::*;
(
    input  logic [$clog2(NPTR)-1:0] sel,
    input  op_e                     op,
    input  xptr_t                   ptr_in  [NPTR],
    output xptr_t                   ptr_out [NPTR]
);
    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        always_comb begin
            ptr_out[g] = ptr_in[g];
            if (int'(sel) == g) begin
                // only the low half moves; the page never sees the carry
                if (op == OP_INC)      ptr_out[g].lo = ptr_in[g].lo + 1'b1;
                else if (op == OP_DEC) ptr_out[g].lo = ptr_in[g].lo - 1'b1;
            end
        end
    end
endmodule

// File: rtl/xaddr_compose.sv
module xaddr_compose
    import xaddr_pkg::*;
(
    input  op_e               op,
    input  xptr_t             cur,
    input  logic [ACC_W-1:0]  acc,
    input  logic [PAGE_W-1:0] code_page,
    output logic              load,
    output logic [ADDR_W-1:0] addr_nx
);
    always_comb begin
        load = forms_addr(op);
        unique case (op)
            OP_XDATA:       addr_nx = {cur.page, cur.lo};
            OP_TBL, OP_JUMP: addr_nx = {code_page, index_add(cur.lo, acc)};
            default:        addr_nx = '0;
        endcase
    end
endmodule

// File: rtl/ext_addr_former.sv
module ext_addr_former
    import xaddr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ptr_sel,
    input  logic [15:0]       ptr0,
    input  logic [15:0]       ptr1,
    input  logic [5:0]        page0,
    input  logic [5:0]        page1,
    input  logic [7:0]        acc,
    input  logic [5:0]        code_page,
    input  logic              op_xdata,
    input  logic              op_tblrd,
    input  logic              op_ijmp,
    input  logic              op_inc,
    input  logic              op_dec,
    output logic [21:0]       addr_q,
    output logic [15:0]       ptr0_nx,
    output logic [15:0]       ptr1_nx,
    output logic [5:0]        page0_nx,
    output logic [5:0]        page1_nx
);
    op_e               op;
    xptr_t             ptrs_in  [NPTR];
    xptr_t             ptrs_out [NPTR];
    xptr_t             cur;
    logic              load;
    logic [ADDR_W-1:0] addr_nx;

    assign ptrs_in[0] = '{page: page0, lo: ptr0};
    assign ptrs_in[1] = '{page: page1, lo: ptr1};
    assign cur        = ptrs_in[ptr_sel];

    xaddr_op_decode u_dec (
        .op_xdata (op_xdata),
        .op_tblrd (op_tblrd),
        .op_ijmp  (op_ijmp),
        .op_inc   (op_inc),
        .op_dec   (op_dec),
        .op       (op)
    );

    xaddr_ptr_step u_step (
        .sel     (ptr_sel),
        .op      (op),
        .ptr_in  (ptrs_in),
        .ptr_out (ptrs_out)
    );

    xaddr_compose u_comp (
        .op        (op),
        .cur       (cur),
        .acc       (acc),
        .code_page (code_page),
        .load      (load),
        .addr_nx   (addr_nx)
    );

    always_ff @(posedge clk) begin
        if (rst)       addr_q <= '0;
        else if (load) addr_q <= addr_nx;
    end

    assign ptr0_nx  = ptrs_out[0].lo;
    assign ptr1_nx  = ptrs_out[1].lo;
    assign page0_nx = ptrs_out[0].page;
    assign page1_nx = ptrs_out[1].page;
endmodule

// File: rtl/xaddr_checker.sv
module xaddr_checker (
    input logic        clk,
    input logic        rst,
    input logic        ptr_sel,
    input logic [15:0] ptr0,
    input logic [15:0] ptr1,
    input logic [5:0]  page0,
    input logic [5:0]  page1,
    input logic [7:0]  acc,
    input logic [5:0]  code_page,
    input logic        op_xdata,
    input logic        op_tblrd,
    input logic        op_ijmp,
    input logic        op_inc,
    input logic        op_dec,
    input logic [21:0] addr_q,
    input logic [15:0] ptr0_nx,
    input logic [15:0] ptr1_nx,
    input logic [5:0]  page0_nx,
    input logic [5:0]  page1_nx
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> addr_q == 22'd0);

    assert_xdata_concat_R2: assert property (@(posedge clk) disable iff (rst)
        op_xdata |=> addr_q == ($past(ptr_sel) ? {$past(page1), $past(ptr1)}
                                               : {$past(page0), $past(ptr0)}));

    assert_index_page_R5: assert property (@(posedge clk) disable iff (rst)
        (!op_xdata && (op_tblrd || op_ijmp)) |=> addr_q[21:16] == $past(code_page));

    assert_pages_kept_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (page0_nx == page0 && page1_nx == page1));

    assert_unsel_kept_R6: assert property (@(posedge clk) disable iff (rst)
        ptr_sel ? (ptr0_nx == ptr0) : (ptr1_nx == ptr1));

    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !(op_xdata || op_tblrd || op_ijmp) |=> $stable(addr_q));
endmodule

bind ext_addr_former xaddr_checker u_chk (.*);

// File: tb/ext_addr_former_test.sv
module ext_addr_former_test;
    logic        clk = 0;
    logic        rst = 1;
    logic        ptr_sel = 0;
    logic [15:0] ptr0 = 0, ptr1 = 0;
    logic [5:0]  page0 = 0, page1 = 0, code_page = 0;
    logic [7:0]  acc = 0;
    logic        op_xdata = 0, op_tblrd = 0, op_ijmp = 0, op_inc = 0, op_dec = 0;
    logic [21:0] addr_q;
    logic [15:0] ptr0_nx, ptr1_nx;
    logic [5:0]  page0_nx, page1_nx;

    int total = 0;
    int bad = 0;
    logic [21:0] exp_addr = 0;

    always #2 clk = ~clk;

    ext_addr_former uut (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // op: 0 none, 1 xdata, 2 tblrd, 3 ijmp, 4 inc, 5 dec
    function automatic logic [21:0] model_addr(input int op, input logic s,
        input logic [15:0] a0, input logic [15:0] a1, input logic [5:0] g0,
        input logic [5:0] g1, input logic [7:0] ac, input logic [5:0] cp,
        input logic [21:0] prev);
        logic [15:0] p = s ? a1 : a0;
        logic [15:0] sum = p + {8'd0, ac};
        if (op == 1) return s ? {g1, a1} : {g0, a0};
        if (op == 2 || op == 3) return {cp, sum};
        return prev;
    endfunction

    task automatic step(input int op, input logic s, input logic [15:0] a0,
        input logic [15:0] a1, input logic [5:0] g0, input logic [5:0] g1,
        input logic [7:0] ac, input logic [5:0] cp);
        logic [15:0] e0 = a0, e1 = a1;
        string tg;
        ptr_sel = s; ptr0 = a0; ptr1 = a1; page0 = g0; page1 = g1; acc = ac; code_page = cp;
        op_xdata = (op == 1); op_tblrd = (op == 2); op_ijmp = (op == 3);
        op_inc = (op == 4); op_dec = (op == 5);
        if (op == 4) begin if (s) e1 = a1 + 16'd1; else e0 = a0 + 16'd1; end
        if (op == 5) begin if (s) e1 = a1 - 16'd1; else e0 = a0 - 16'd1; end
        tg = (op == 4) ? "R3" : (op == 5) ? "R4" : "R6";
        #1;
        check({tg, " ptr0"}, {16'd0, ptr0_nx}, {16'd0, e0});
        check({tg, " ptr1"}, {16'd0, ptr1_nx}, {16'd0, e1});
        check({tg, " pages"}, {20'd0, page1_nx, page0_nx}, {20'd0, g1, g0});
        exp_addr = model_addr(op, s, a0, a1, g0, g1, ac, cp, exp_addr);
        tg = (op == 1) ? "R2" : (op == 2 || op == 3) ? (ac[7] ? "R8" : "R5") : "R7";
        @(posedge clk); #1;
        check({tg, " addr"}, {10'd0, addr_q}, {10'd0, exp_addr});
        op_xdata = 0; op_tblrd = 0; op_ijmp = 0; op_inc = 0; op_dec = 0;
    endtask

    initial begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        op_xdata = 1; ptr0 = 16'h1234; page0 = 6'h2A;
        @(posedge clk); #1;
        check("R1 reset", {10'd0, addr_q}, 32'd0);
        rst = 0;
        op_xdata = 0;
        exp_addr = 0;
        // directed corners
        step(1, 0, 16'hBEEF, 16'h0101, 6'h15, 6'h2A, 8'h00, 6'h01);
        step(1, 1, 16'hBEEF, 16'h0101, 6'h15, 6'h2A, 8'h00, 6'h01);
        step(0, 1, 16'h0000, 16'h0000, 6'h3F, 6'h3F, 8'hFF, 6'h3F);
        step(4, 0, 16'hFFFF, 16'h5555, 6'h07, 6'h09, 8'h00, 6'h00);
        step(5, 1, 16'h1111, 16'h0000, 6'h07, 6'h09, 8'h00, 6'h00);
        step(2, 0, 16'hFFF0, 16'h0000, 6'h3F, 6'h3F, 8'h20, 6'h05);
        step(3, 1, 16'h0000, 16'hFF80, 6'h11, 6'h22, 8'h80, 6'h33);
        step(2, 1, 16'h0000, 16'h0010, 6'h11, 6'h22, 8'hFF, 6'h00);
        step(0, 0, 16'h9999, 16'h8888, 6'h01, 6'h02, 8'h01, 6'h03);
        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [15:0] r0 = 16'($urandom);
            logic [15:0] r1 = 16'($urandom);
            if ($urandom % 8 == 0) r0 = ($urandom % 2) ? 16'hFFFF : 16'h0000;
            if ($urandom % 8 == 0) r1 = ($urandom % 2) ? 16'hFFFF : 16'h0000;
            step(int'($urandom % 6), 1'($urandom), r0, r1, 6'($urandom),
                 6'($urandom), 8'($urandom), 6'($urandom));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule